// File: doc/BRIEF.md
# RMII Receive Destination-Address Filter

This block listens to the receive side of a two-bit reduced media-independent interface (RMII) running on the 50 MHz reference clock. It watches the shared carrier/data-valid line and the receive dibits. It finds the start of each preamble and locks onto the start-of-frame delimiter. It then collects the 48-bit destination address and looks it up in a small programmable table. When the address is not acceptable, it raises a single `reject` line that tells the downstream MAC to drop the frame. That line is held until a fixed number of clocks after the frame ends.

The carrier/data-valid input can rise at any moment, so it passes through a two-stage synchronizer. The receive data passes through a matching two-stage delay, so that both stay aligned. The end of a frame is judged on these synchronized samples. A single low sample of carrier/data-valid while data is still non-zero does not end the frame. The table entries and their enable bits are static configuration inputs.

Top module: `rmii_da_filter`

## Requirements
- R1: After reset, and while no frame is seen, `reject` is 0.
- R2: `crs_dv` and `rxd` each pass through two register stages before any decision. A frame starts only when the synchronized `crs_dv` is 1 and the synchronized `rxd` moves from 00 to 01. The delimiter is a 11 dibit that directly follows a 01 dibit.
- R3: The 24 dibits after the delimiter form the address. Wire byte n (n = 0..5) is bits [47-8n : 40-8n] of the 48-bit value. Within each byte, bits [1:0] arrive first. `rxd[0]` is the lower bit of each dibit.
- R4: An address equal to an entry whose enable bit is 1 is accepted, and `reject` stays 0 for that frame.
- R5: An entry whose enable bit is 0 takes no part in matching.
- R6: The all-ones address is accepted even when every entry is disabled.
- R7: For a rejected address, `reject` rises at the second clock edge after the edge that samples the last address dibit in the synchronized stream.
- R8: The frame ends when the synchronized `crs_dv` is 0 on two consecutive samples, or when it is 0 while `rxd` is 00. A single low sample with non-zero `rxd` does not end the frame.
- R9: Once raised, `reject` stays 1 and falls at the fourth clock edge after the edge that samples the end condition (hold HOLD = 3 cycles).
- R10: A frame that ends before all 24 address dibits are taken is rejected. This includes a frame that ends during the preamble. Here `reject` rises at the edge after the end is sampled and then follows R9.
- R11: When the lookup result for a rejected address and the end of the frame arrive in the same cycle, `reject` is still raised and held as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crs_dv | input | 1 | Carrier sense / data valid, possibly asynchronous |
| rxd | input | 2 | Receive dibit |
| tbl_addr | input | ENTRIES*48 | Table addresses, entry i at bits [48i+47:48i] |
| tbl_en | input | ENTRIES | Per-entry enable |
| reject | output | 1 | Discard request for the current frame |

## Verification
The lookup result and the end-of-frame detection can land in the same cycle. This happens when a frame that fails the lookup ends with no payload after its last address dibit. The bench sends such frames, both failing and passing, and compares `reject` on every clock against its behavioural model. The failing frame must still raise `reject` and hold it for the full interval. The passing frame must leave `reject` low. Short frames that end inside the preamble or inside the address are judged the same way. So are frames with a single carrier dip in the payload.

// File: rtl/rmii_flt_pkg.sv
package rmii_flt_pkg;
  localparam int DA_BITS = 48;
  localparam int DA_DIBITS = DA_BITS / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ADDR,
    ST_BODY
  } rx_state_t;

  // Place dibit number k of the address into its bit slot:
  // wire byte k/4 is the more significant end, low bits of a byte first.
  function automatic logic [DA_BITS-1:0] put_dibit(input logic [DA_BITS-1:0] a,
                                                   input int unsigned k,
                                                   input logic [1:0] d);
    logic [DA_BITS-1:0] r;
    int unsigned idx;
    r = a;
    idx = (DA_BITS - 8) - 8 * (k / 4) + 2 * (k % 4);
    r[idx +: 2] = d;
    return r;
  endfunction

  // End of frame on the synchronized samples.
  function automatic logic end_seen(input logic crs, input logic crs_prev,
                                    input logic [1:0] d);
    return !crs && (!crs_prev || d == 2'b00);
  endfunction
endpackage

// File: rtl/rmii_sync.sv
module rmii_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/rmii_frame_fsm.sv
module rmii_frame_fsm
  import rmii_flt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_crs,
  input  logic [1:0]         s_rxd,
  output logic [DA_BITS-1:0] addr,
  output logic               addr_valid,
  output logic               end_pulse,
  output logic               short_end,
  output logic               in_frame
);
  localparam int CW = $clog2(DA_DIBITS);

  rx_state_t      state;
  logic           p_crs;
  logic [1:0]     p_rxd;
  logic [CW-1:0]  cnt;
  logic           end_now;
  logic           sfd_now;
  logic           start_now;

  assign end_now   = end_seen(s_crs, p_crs, s_rxd);
  assign sfd_now   = (p_rxd == 2'b01) && (s_rxd == 2'b11);
  assign start_now = s_crs && (p_rxd == 2'b00) && (s_rxd == 2'b01);
  assign in_frame  = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      p_crs      <= 1'b0;
      p_rxd      <= 2'b00;
      cnt        <= '0;
      addr       <= '0;
      addr_valid <= 1'b0;
      end_pulse  <= 1'b0;
      short_end  <= 1'b0;
    end else begin
      p_crs      <= s_crs;
      p_rxd      <= s_rxd;
      addr_valid <= 1'b0;
      end_pulse  <= 1'b0;
      short_end  <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_now) state <= ST_PRE;
        ST_PRE: begin
          if (end_now) begin
            state     <= ST_IDLE;
            end_pulse <= 1'b1;
            short_end <= 1'b1;
          end else if (sfd_now) begin
            state <= ST_ADDR;
            cnt   <= '0;
          end
        end
        ST_ADDR: begin
          if (end_now) begin
            state     <= ST_IDLE;
            end_pulse <= 1'b1;
            short_end <= 1'b1;
          end else begin
            addr <= put_dibit(addr, int'(cnt), s_rxd);
            cnt  <= cnt + 1'b1;
            if (cnt == CW'(DA_DIBITS - 1)) begin
              state      <= ST_BODY;
              addr_valid <= 1'b1;
            end
          end
        end
        ST_BODY: begin
          if (end_now) begin
            state     <= ST_IDLE;
            end_pulse <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: a lone low sample with live data keeps the frame open
  p_single_dip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !s_crs && p_crs && s_rxd != 2'b00) |=> in_frame);

  // R3: the address is complete only after a run through the address state
  p_addr_after_gather_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (state == ST_BODY || state == ST_IDLE));
endmodule

// File: rtl/rmii_addr_match.sv
module rmii_addr_match
  import rmii_flt_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DA_BITS-1:0]         addr,
  input  logic                       addr_valid,
  input  logic [ENTRIES*DA_BITS-1:0] tbl_addr,
  input  logic [ENTRIES-1:0]         tbl_en,
  output logic                       res_miss
);
  logic [ENTRIES-1:0] hit_vec;
  logic               bcast;
  logic               hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hit_vec[i] = tbl_en[i] && (addr == tbl_addr[i*DA_BITS +: DA_BITS]);
  end

  assign bcast = &addr;
  assign hit   = bcast || (|hit_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_miss <= 1'b0;
    else        res_miss <= addr_valid && !hit;
  end

  p_bcast_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && (&addr)) |=> !res_miss);

  p_disabled_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && tbl_en == '0 && !(&addr)) |=> res_miss);
endmodule

// File: rtl/rmii_da_filter.sv
module rmii_da_filter
  import rmii_flt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int HOLD = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       crs_dv,
  input  logic [1:0]                 rxd,
  input  logic [ENTRIES*DA_BITS-1:0] tbl_addr,
  input  logic [ENTRIES-1:0]         tbl_en,
  output logic                       reject
);
  localparam int HW = $clog2(HOLD + 1);

  logic               s_crs;
  logic [1:0]         s_rxd;
  logic [DA_BITS-1:0] addr;
  logic               addr_valid;
  logic               end_pulse;
  logic               short_end;
  logic               in_frame;
  logic               res_miss;
  logic [HW-1:0]      hold_cnt;

  rmii_sync #(.W(1), .STAGES(SYNC_STAGES)) u_crs_sync (
    .clk(clk), .rst_n(rst_n), .din(crs_dv), .dout(s_crs));

  rmii_sync #(.W(2), .STAGES(SYNC_STAGES)) u_rxd_dly (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(s_rxd));

  rmii_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .s_crs(s_crs), .s_rxd(s_rxd),
    .addr(addr), .addr_valid(addr_valid), .end_pulse(end_pulse),
    .short_end(short_end), .in_frame(in_frame));

  rmii_addr_match #(.ENTRIES(ENTRIES)) u_match (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
    .tbl_addr(tbl_addr), .tbl_en(tbl_en), .res_miss(res_miss));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reject   <= 1'b0;
      hold_cnt <= '0;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - HW'(1);
      if (hold_cnt == HW'(1)) reject <= 1'b0;
    end else if (end_pulse && (reject || res_miss || short_end)) begin
      reject   <= 1'b1;
      hold_cnt <= HW'(HOLD);
    end else if (res_miss) begin
      reject <= 1'b1;
    end
  end

  p_miss_raises_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |=> reject);

  p_rise_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reject) |-> ($past(res_miss) || $past(end_pulse && short_end)));

  p_short_raises_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (end_pulse && short_end) |=> reject);

  p_hold_after_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_pulse && reject) |=> reject);

  p_fall_outside_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reject) |-> !in_frame);

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (end_pulse && res_miss) |=> reject);
endmodule

// File: tb/rmii_da_filter_test.sv
`timescale 1ns/1ps
module rmii_da_filter_test;
  localparam int HOLD = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         crs_dv = 1'b0;
  logic [1:0]   rxd = 2'b00;
  logic [47:0]  tbl [4];
  logic [3:0]   tbl_en;
  logic [191:0] tbl_flat;
  logic         reject;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit    started = 0;
  bit    saw_rej = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 4; i++) tbl_flat[i*48 +: 48] = tbl[i];
  end

  rmii_da_filter uut (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd),
    .tbl_addr(tbl_flat), .tbl_en(tbl_en), .reject(reject));

  // Behavioural reference model.
  bit       m_c1, m_c2, m_pc;
  bit [1:0] m_r1, m_r2, m_pr;
  int       m_state;   // 0 idle, 1 preamble, 2 address, 3 payload
  int       m_k;
  byte unsigned m_bytes [6];
  bit       m_av, m_end, m_short, m_miss, m_rej;
  int       m_hold;

  function automatic bit accepted();
    bit [47:0] v = 0;
    bit all1 = 1;
    for (int b = 0; b < 6; b++) begin
      v = {v[39:0], m_bytes[b]};
      if (m_bytes[b] != 8'hFF) all1 = 0;
    end
    if (all1) return 1;
    for (int i = 0; i < 4; i++) if (tbl_en[i] && tbl[i] == v) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin : mdl
    bit ec, n_end, n_short, n_av, n_miss;
    started = 1;
    if (!rst_n) begin
      m_c1 = 0; m_c2 = 0; m_pc = 0; m_r1 = 0; m_r2 = 0; m_pr = 0;
      m_state = 0; m_k = 0; m_av = 0; m_end = 0; m_short = 0;
      m_miss = 0; m_rej = 0; m_hold = 0;
    end else begin
      ec = !m_c2 && (!m_pc || m_r2 == 2'b00);
      n_end = 0; n_short = 0; n_av = 0;
      if (m_hold > 0) begin
        if (m_hold == 1) m_rej = 0;
        m_hold--;
      end else if (m_end && (m_rej || m_miss || m_short)) begin
        m_rej = 1; m_hold = HOLD;
      end else if (m_miss) m_rej = 1;
      n_miss = m_av && !accepted();
      case (m_state)
        0: if (m_c2 && m_pr == 2'b00 && m_r2 == 2'b01) m_state = 1;
        1: if (ec) begin m_state = 0; n_end = 1; n_short = 1; end
           else if (m_pr == 2'b01 && m_r2 == 2'b11) begin m_state = 2; m_k = 0; end
        2: if (ec) begin m_state = 0; n_end = 1; n_short = 1; end
           else begin
             if (m_k % 4 == 0) m_bytes[m_k/4] = 0;
             m_bytes[m_k/4] = m_bytes[m_k/4] | (8'(m_r2) << (2 * (m_k % 4)));
             m_k++;
             if (m_k == 24) begin m_state = 3; n_av = 1; end
           end
        default: if (ec) begin m_state = 0; n_end = 1; end
      endcase
      m_pc = m_c2; m_pr = m_r2;
      m_c2 = m_c1; m_c1 = crs_dv;
      m_r2 = m_r1; m_r1 = rxd;
      m_end = n_end; m_short = n_short; m_av = n_av; m_miss = n_miss;
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (reject !== m_rej) begin
        errors++;
        $display("FAIL %s cycle compare: reject=%0b expected=%0b at %0t",
                 cur_tag, reject, m_rej, $time);
      end
      if (reject === 1'b1) saw_rej = 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); crs_dv = 0; rxd = 2'b00; end
  endtask

  // endm 0: low with 00; endm 1: two low samples with non-zero data.
  // cut >= 0: stop after that many address dibits (cut 0 ends in preamble).
  task automatic send_frame(input logic [47:0] da, input int pre, input int body,
                            input int endm, input int cut, input int glitch,
                            input bit expect_rej, input string tag);
    cur_tag = tag;
    saw_rej = 0;
    @(negedge clk); crs_dv = 1; rxd = 2'b00;
    for (int i = 0; i < pre; i++) begin @(negedge clk); rxd = 2'b01; end
    if (cut != 0) begin
      @(negedge clk); rxd = 2'b11;
      for (int k = 0; k < 24; k++) begin
        if (cut > 0 && k == cut) break;
        @(negedge clk);
        rxd = 2'((da >> (40 - 8 * (k / 4) + 2 * (k % 4))) & 48'd3);
      end
      if (cut < 0) begin
        for (int i = 0; i < body; i++) begin
          @(negedge clk);
          if (glitch != 0 && i == body / 2) begin crs_dv = 0; rxd = 2'b10; end
          else begin crs_dv = 1; rxd = 2'((i * 7 + 3) % 4); end
        end
      end
    end
    if (endm == 0) begin
      @(negedge clk); crs_dv = 0; rxd = 2'b00;
    end else begin
      @(negedge clk); crs_dv = 0; rxd = 2'b01;
      @(negedge clk); crs_dv = 0; rxd = 2'b10;
    end
    idle(14);
    checks++;
    if (saw_rej != expect_rej) begin
      errors++;
      $display("FAIL %s frame outcome: reject seen=%0b expected=%0b", tag, saw_rej, expect_rej);
    end
  endtask

  initial begin
    tbl[0] = 48'h02_11_22_33_44_55;
    tbl[1] = 48'h0A_BC_DE_F0_12_34;
    tbl[2] = 48'h5C_00_00_00_00_01;
    tbl[3] = 48'h06_66_77_88_99_AA;
    tbl_en = 4'b0111;
    repeat (3) @(negedge clk);
    checks++;
    if (reject !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: reject=%0b expected=0", reject);
    end
    rst_n = 1;
    idle(10);
    checks++;
    if (reject !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: reject=%0b expected=0", reject);
    end
    send_frame(tbl[0], 7, 40, 0, -1, 0, 0, "R4");
    send_frame(tbl[1], 3, 20, 1, -1, 0, 0, "R3");
    send_frame(48'h12_34_56_78_9A_BC, 7, 40, 0, -1, 0, 1, "R7");
    send_frame(tbl[3], 5, 30, 0, -1, 0, 1, "R5");
    send_frame(48'hFF_FF_FF_FF_FF_FF, 7, 30, 0, -1, 0, 0, "R6");
    send_frame(48'h12_34_56_78_9A_BC, 7, 30, 1, -1, 1, 1, "R8");
    send_frame(tbl[2], 7, 30, 0, -1, 1, 0, "R8");
    send_frame(48'h12_34_56_78_9A_BC, 7, 30, 1, -1, 0, 1, "R9");
    send_frame(tbl[0], 7, 0, 0, 10, 0, 1, "R10");
    send_frame(tbl[0], 7, 0, 0, 0, 0, 1, "R10");
    send_frame(48'h77_00_00_00_00_00, 7, 0, 0, -1, 0, 1, "R11");
    send_frame(tbl[1], 7, 0, 0, -1, 0, 0, "R11");
    send_frame(48'h77_00_00_00_00_00, 7, 0, 1, -1, 0, 1, "R11");
    // Data that never shows 00 -> 01 with carrier must not start a frame.
    cur_tag = "R2";
    saw_rej = 0;
    @(negedge clk); crs_dv = 0; rxd = 2'b01;
    for (int i = 0; i < 30; i++) begin @(negedge clk); crs_dv = 0; rxd = 2'((i % 3) + 1); end
    idle(10);
    checks++;
    if (saw_rej != 0) begin
      errors++;
      $display("FAIL R2 no start: reject seen=%0b expected=0", saw_rej);
    end
    tbl_en = 4'b0000;
    idle(2);
    send_frame(48'hFF_FF_FF_FF_FF_FF, 4, 20, 0, -1, 0, 0, "R6");
    send_frame(tbl[0], 4, 20, 0, -1, 0, 1, "R5");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL R1 watchdog: run=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule